// File: doc/BRIEF.md
# Receive Byte Ordering Aligner

This block sits behind a word aligner on a receive path that delivers two bytes per clock. After the word aligner locks, the byte boundaries are correct, but the two bytes of a word can still be in the wrong lanes. The block scans the incoming words for a known ordering byte. If that byte turns up in the upper lane, the block inserts a single pad byte. From then on the stream runs one byte later, so the ordering byte and everything after it land in the intended lanes.

A search is started by an edge, not by a level. A synthesis-time mode picks which input provides the edge: either the word-aligner sync indication or a user request input. The search ends when the ordering byte is found. The status flag then rises, and it rises whether or not a pad was needed. The chosen byte shift holds until the next start edge, which clears the status, removes the shift and searches again.

Top module: `byte_order_align`

## Requirements
- R1: While reset is held and on the first cycle after it, `ordered` is 0 and `out_word` is 0. After that the block passes words straight through with no byte shift until a search succeeds.
- R2: With `TRIG_MODE` = TRIG_SYNC, a 0-to-1 transition of `sync_ok` (sampled at consecutive clock edges) starts a search.
- R3: When a search finds `ORDER_PAT` in the lower lane (bits [7:0]), `ordered` rises with no byte shift. `out_word` equals `rx_word` delayed by one clock, both for that word and for all later words.
- R4: When a search finds `ORDER_PAT` only in the upper lane (bits [15:8]), the output word registered on that clock is {`PAD_BYTE`, lower byte of that input word}. Every later output word is {lower byte of the current input, upper byte of the previous input}.
- R5: `ordered` rises on the clock that registers the word holding the ordering byte, whether or not a pad byte was inserted.
- R6: A new start edge while aligned drops `ordered` to 0 on that clock, removes any byte shift from the next output word on, and starts a new search.
- R7: Holding the trigger input high starts no further search. Once found, `ordered` and the byte shift do not change even if `ORDER_PAT` shows up again in the other lane.
- R8: With `TRIG_MODE` = TRIG_USER, a 0-to-1 transition of `order_req` starts the search, and `sync_ok` has no effect. In TRIG_SYNC mode, `order_req` has no effect.
- R9: Before any start edge, words that contain `ORDER_PAT` in either lane leave `ordered` at 0 and pass through unchanged.
- R10: When both lanes of one searched word equal `ORDER_PAT`, the lower lane wins and no pad is inserted.
- R11: The word presented on the same clock as the start edge is already searched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive parallel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_ok | input | 1 | Word-aligner lock indication; rising edge starts a search in TRIG_SYNC mode |
| order_req | input | 1 | User search request; rising edge starts a search in TRIG_USER mode |
| rx_word | input | 2*BYTE_W | Incoming word, lower lane is the earlier byte |
| out_word | output | 2*BYTE_W | Reordered word, one clock after input |
| ordered | output | 1 | High once the ordering byte has been found since the last start edge |

## Verification
The bench runs the ordering byte in the lower lane, in the upper lane and in both lanes, at zero to three words after the start edge. This separates the no-pad path, the pad path with its lasting one-byte shift, the lower-lane priority rule and the same-clock search. Each run is repeated with each mode driven, while an instance configured for the other mode watches the same inputs. That shows each mode reacts only to its own input. A sweep over all byte values before any start edge shows that pattern bytes are ignored while idle. Re-trigger sequences show that a held level does nothing and a new edge clears both status and shift.

// File: rtl/byte_order_pkg.sv
package byte_order_pkg;

   // Which input provides the search-start edge.
   typedef enum logic {
      TRIG_SYNC = 1'b0,
      TRIG_USER = 1'b1
   } trig_src_e;

   // Number of byte lanes on the datapath.
   localparam int unsigned LANES = 2;

endpackage

// File: rtl/bo_trig_edge.sv
module bo_trig_edge
   import byte_order_pkg::*;
#(
   parameter trig_src_e SRC = TRIG_SYNC
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_lvl,
   input  logic user_lvl,
   output logic rise
);

   logic sel_lvl;
   logic lvl_q;

   // Source chosen by mode; the other input is ignored.
   always_comb sel_lvl = (SRC == TRIG_USER) ? user_lvl : sync_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= sel_lvl;
   end

   assign rise = sel_lvl & ~lvl_q;

endmodule

// File: rtl/bo_lane_match.sv
module bo_lane_match
   import byte_order_pkg::*;
#(
   parameter int unsigned           BYTE_W  = 8,
   parameter logic [BYTE_W-1:0]     PAT     = 8'hBC
) (
   input  logic [LANES*BYTE_W-1:0] word,
   output logic [LANES-1:0]        hit
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign hit[l] = (word[l*BYTE_W +: BYTE_W] == PAT);
   end

endmodule

// File: rtl/bo_search_ctl.sv
module bo_search_ctl
   import byte_order_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic [LANES-1:0] hit,
   output logic             ordered,
   output logic             shift,
   output logic             pad_now
);

   logic searching;
   logic look;
   logic found_lo;
   logic found_hi;

   // The start-edge word is already inspected.
   always_comb begin
      look     = rise | searching;
      found_lo = look & hit[0];
      found_hi = look & hit[1] & ~hit[0];
   end

   assign pad_now = found_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         searching <= 1'b0;
         ordered   <= 1'b0;
         shift     <= 1'b0;
      end else begin
         if (rise) begin
            searching <= 1'b1;
            ordered   <= 1'b0;
            shift     <= 1'b0;
         end
         if (found_lo | found_hi) begin
            searching <= 1'b0;
            ordered   <= 1'b1;
            shift     <= found_hi;
         end
      end
   end

endmodule

// File: rtl/bo_lane_shift.sv
module bo_lane_shift #(
   parameter int unsigned       BYTE_W = 8,
   parameter logic [BYTE_W-1:0] PAD    = 8'h9C
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*BYTE_W-1:0] word,
   input  logic                shift,
   input  logic                pad_now,
   output logic [2*BYTE_W-1:0] out_word
);

   localparam int unsigned WORD_W = 2*BYTE_W;

   logic [BYTE_W-1:0] lo_b;
   logic [BYTE_W-1:0] hi_b;
   logic [BYTE_W-1:0] hi_q;
   logic [WORD_W-1:0] nxt;

   assign lo_b = word[BYTE_W-1:0];
   assign hi_b = word[WORD_W-1:BYTE_W];

   always_comb begin
      if (pad_now)    nxt = {PAD, lo_b};
      else if (shift) nxt = {lo_b, hi_q};
      else            nxt = word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q     <= '0;
         out_word <= '0;
      end else begin
         hi_q     <= hi_b;
         out_word <= nxt;
      end
   end

endmodule

// File: rtl/byte_order_align.sv
module byte_order_align
   import byte_order_pkg::*;
#(
   parameter int unsigned       BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] ORDER_PAT = 8'hBC,
   parameter logic [BYTE_W-1:0] PAD_BYTE  = 8'h9C,
   parameter trig_src_e         TRIG_MODE = TRIG_SYNC
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sync_ok,
   input  logic                order_req,
   input  logic [2*BYTE_W-1:0] rx_word,
   output logic [2*BYTE_W-1:0] out_word,
   output logic                ordered
);

   if (BYTE_W < 4) begin : g_bad_width
      $error("byte_order_align: BYTE_W must be at least 4");
   end
   if (ORDER_PAT == PAD_BYTE) begin : g_bad_pad
      $error("byte_order_align: PAD_BYTE must differ from ORDER_PAT");
   end

   logic             rise;
   logic [LANES-1:0] hit;
   logic             shift;
   logic             pad_now;

   bo_trig_edge #(.SRC(TRIG_MODE)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_lvl (sync_ok),
      .user_lvl (order_req),
      .rise     (rise)
   );

   bo_lane_match #(.BYTE_W(BYTE_W), .PAT(ORDER_PAT)) u_match (
      .word (rx_word),
      .hit  (hit)
   );

   bo_search_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise),
      .hit     (hit),
      .ordered (ordered),
      .shift   (shift),
      .pad_now (pad_now)
   );

   bo_lane_shift #(.BYTE_W(BYTE_W), .PAD(PAD_BYTE)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .word     (rx_word),
      .shift    (shift),
      .pad_now  (pad_now),
      .out_word (out_word)
   );

endmodule

// File: rtl/byte_order_align_chk.sv
module byte_order_align_chk
   import byte_order_pkg::*;
#(
   parameter int unsigned       BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] ORDER_PAT = 8'hBC,
   parameter logic [BYTE_W-1:0] PAD_BYTE  = 8'h9C,
   parameter trig_src_e         TRIG_MODE = TRIG_SYNC
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sync_ok,
   input logic                order_req,
   input logic [2*BYTE_W-1:0] rx_word,
   input logic [2*BYTE_W-1:0] out_word,
   input logic                ordered
);

   logic trig;
   logic trig_prev;
   logic trig_edge;
   logic lo_pat;
   logic hi_pat;

   assign trig      = (TRIG_MODE == TRIG_USER) ? order_req : sync_ok;
   assign trig_edge = trig & ~trig_prev;
   assign lo_pat    = (rx_word[BYTE_W-1:0] == ORDER_PAT);
   assign hi_pat    = (rx_word[2*BYTE_W-1:BYTE_W] == ORDER_PAT);

   always_ff @(posedge clk) begin
      if (!rst_n) trig_prev <= 1'b0;
      else        trig_prev <= trig;
   end

   // R5
   rose_needs_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ordered) |-> $past(lo_pat || hi_pat));

   // R6
   fall_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ordered) |-> $past(trig_edge));

   // R3
   lower_lane_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ordered) && $past(lo_pat) |-> out_word == $past(rx_word));

   // R4
   pad_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ordered) && !$past(lo_pat) |-> out_word == {PAD_BYTE, $past(rx_word[BYTE_W-1:0])});

   // R7
   hold_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ordered && !trig_edge |=> ordered);

endmodule

bind byte_order_align byte_order_align_chk #(
   .BYTE_W    (BYTE_W),
   .ORDER_PAT (ORDER_PAT),
   .PAD_BYTE  (PAD_BYTE),
   .TRIG_MODE (TRIG_MODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync_ok   (sync_ok),
   .order_req (order_req),
   .rx_word   (rx_word),
   .out_word  (out_word),
   .ordered   (ordered)
);

// File: tb/byte_order_align_bench.sv
`timescale 1ns/1ps
module byte_order_align_bench;
   import byte_order_pkg::*;

   localparam logic [7:0] PAT = 8'hBC;
   localparam logic [7:0] PAD = 8'h9C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_ok = 1'b0;
   logic        order_req = 1'b0;
   logic [15:0] rx_word = '0;
   logic [15:0] out_s, out_u;
   logic        ord_s, ord_u;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   byte_order_align #(.BYTE_W(8), .ORDER_PAT(PAT), .PAD_BYTE(PAD), .TRIG_MODE(TRIG_SYNC)) u_byte_order_align (
      .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .order_req(order_req),
      .rx_word(rx_word), .out_word(out_s), .ordered(ord_s));

   byte_order_align #(.BYTE_W(8), .ORDER_PAT(PAT), .PAD_BYTE(PAD), .TRIG_MODE(TRIG_USER)) u_byte_order_align_usr (
      .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .order_req(order_req),
      .rx_word(rx_word), .out_word(out_u), .ordered(ord_u));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Apply inputs, let one edge register them, sample 1 ns later.
   task automatic step(input logic [15:0] w, input logic s, input logic u);
      rx_word = w; sync_ok = s; order_req = u;
      @(posedge clk); #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; sync_ok = 1'b0; order_req = 1'b0; rx_word = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 ordered in reset", {15'd0, ord_s | ord_u}, 16'd0);
      chk("R1 out in reset", out_s | out_u, 16'd0);
      rst_n = 1'b1;
   endtask

   // user: which instance is driven; lane: 0 lower, 1 upper, 2 both; gap: words after edge
   task automatic run_case(input bit user, input int lane, input int gap);
      logic [15:0] w, pw, ob;
      logic [7:0]  prev_hi;
      logic        shifted;
      logic        s_on, u_on;
      s_on = !user; u_on = user;
      do_reset();
      // R9: pattern before any start edge is ignored
      w = {PAT, 8'h21};
      step(w, 1'b0, 1'b0);
      chk("R9 idle ordered", {15'd0, ord_s | ord_u}, 16'd0);
      chk("R9 idle passthrough", user ? out_u : out_s, w);
      // words from the start edge (first loop pass) up to the pattern
      for (int k = 0; k < gap; k++) begin
         w = {8'h30 + 8'(k), 8'h50 + 8'(k)};
         step(w, s_on, u_on);
         chk(user ? "R8 searching ordered" : "R2 searching ordered",
             {15'd0, user ? ord_u : ord_s}, 16'd0);
         chk("R9 pass while searching", user ? out_u : out_s, w);
      end
      pw = (lane == 0) ? {8'h11, PAT} : (lane == 1) ? {PAT, 8'h12} : {PAT, PAT};
      step(pw, s_on, u_on);
      // R5/R11: found on the edge that registers the pattern word
      chk(gap == 0 ? "R11 found on edge word" : "R5 ordered after find",
          {15'd0, user ? ord_u : ord_s}, 16'd1);
      chk("R8 other mode ignores input", {15'd0, user ? ord_s : ord_u}, 16'd0);
      ob = (lane == 1) ? {PAD, 8'h12} : pw;
      chk(lane == 1 ? "R4 pad word" : (lane == 2 ? "R10 both lanes no pad" : "R3 lower no shift"),
          user ? out_u : out_s, ob);
      shifted = (lane == 1);
      prev_hi = pw[15:8];
      // R7: trigger held high, pattern in the other lane changes nothing
      for (int k = 0; k < 3; k++) begin
         w = {8'h60 + 8'(k), 8'h70 + 8'(k)};
         if (k == 1) w = shifted ? {8'h61, PAT} : {PAT, 8'h71};
         step(w, s_on, u_on);
         ob = shifted ? {w[7:0], prev_hi} : w;
         chk(shifted ? "R4 lasting shift" : "R7 no new pad", user ? out_u : out_s, ob);
         chk("R7 ordered held", {15'd0, user ? ord_u : ord_s}, 16'd1);
         prev_hi = w[15:8];
      end
      // R7: falling level does nothing
      step(16'h2233, 1'b0, 1'b0);
      chk("R7 level drop keeps ordered", {15'd0, user ? ord_u : ord_s}, 16'd1);
      // R6: new edge clears status and shift
      step(16'h4455, s_on, u_on);
      chk("R6 edge clears ordered", {15'd0, user ? ord_u : ord_s}, 16'd0);
      step(16'h6677, s_on, u_on);
      chk("R6 shift removed", user ? out_u : out_s, 16'h6677);
      step({8'h13, PAT}, s_on, u_on);
      chk("R6 re-search finds", {15'd0, user ? ord_u : ord_s}, 16'd1);
      chk("R6 re-search no pad", user ? out_u : out_s, {8'h13, PAT});
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 16'd1, 16'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R9 sweep: every byte value in both lanes with no start edge
      for (int v = 0; v < 256; v++) begin
         step({8'(v), 8'(v) ^ 8'h5A}, 1'b0, 1'b0);
         chk("R9 sweep ordered", {15'd0, ord_s | ord_u}, 16'd0);
         chk("R1 sweep passthrough", out_s, {8'(v), 8'(v) ^ 8'h5A});
      end
      for (int m = 0; m < 2; m++)
         for (int l = 0; l < 3; l++)
            for (int g = 0; g < 4; g++)
               run_case(m[0], l, g);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule